// File: doc/BRIEF.md
# MAC Transmit/Receive Run Gate

This block decides, cycle by cycle, whether the transmit path and the receive path of an Ethernet MAC may move frame data. Each direction is governed by two control bits held in the block: a run bit and a graceful-stop bit. A third, sticky control bit re-initialises both directions at once. The host loads all five bits together with a single write strobe.

The block follows frame boundaries on each path through start-of-frame and end-of-frame strobes. This lets it tell two kinds of stop apart. Dropping the run bit cuts the path at once, even in the middle of a frame, and raises a one-cycle abort strobe so the path can truncate the frame and mark it bad. Raising the graceful-stop bit lets the frame in flight run to its end and then refuses new ones. Each direction reports whether it is open for new frames and whether it has gone quiet. The datapath uses the gate output to pass or block data beats, the active output to decide whether it may begin a frame, and the abort output to discard a partly sent or partly received frame.

Top module: `mac_run_gate`

## Requirements
- R1: While rst_n is low at a clock edge, all five control bits read 0, and both directions show gate=0, abort=0, active=0, idle=1.
- R2: A write (cfg_wr=1 at a clock edge) loads the five control bits, which appear on the stat_* outputs after that edge and keep their value until the next write.
- R3: A direction is active, and accepts a start-of-frame strobe, only while its run bit is 1 and its stop bit is 0. A start-of-frame strobe seen at an edge where the direction was not active is ignored and opens no frame.
- R4: If the run bit of a direction is 0 while a frame is open, the gate output is 0 at once, abort is 1 for exactly one cycle, and the frame is closed after that cycle.
- R5: If the stop bit is 1 while the run bit is 1 and a frame is open, the gate stays 1 and abort stays 0 until the end-of-frame strobe. After that edge the gate is 0 and no new frame starts.
- R6: The transmit and receive directions are independent. An abort, a stop or a frame on one direction does not change the outputs of the other.
- R7: A write with cfg_reinit=1 leaves, after its edge, the reinit bit at 1, both stop bits at 1 and both run bits at 0, so any open frame on either direction aborts as in R4.
- R8: In a write with cfg_reinit=1, run bits requested as 1 are forced to 0.
- R9: The reinit bit stays 1 until a write with cfg_reinit=0. That write clears it and loads its other four bits as given.
- R10: idle is 1 exactly when the direction has no open frame and is not active. It goes to 0 while a frame drains under a stop, and while the direction is open for new frames.
- R11: A start-of-frame and end-of-frame strobe in the same cycle forms a complete single-beat frame and leaves no frame open. An end-of-frame strobe with no frame open has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_wr | input | 1 | Control write strobe |
| cfg_tx_run | input | 1 | Write data: transmit run bit |
| cfg_tx_stop | input | 1 | Write data: transmit graceful-stop bit |
| cfg_rx_run | input | 1 | Write data: receive run bit |
| cfg_rx_stop | input | 1 | Write data: receive graceful-stop bit |
| cfg_reinit | input | 1 | Write data: sticky re-initialise bit |
| stat_tx_run | output | 1 | Current transmit run bit |
| stat_tx_stop | output | 1 | Current transmit stop bit |
| stat_rx_run | output | 1 | Current receive run bit |
| stat_rx_stop | output | 1 | Current receive stop bit |
| stat_reinit | output | 1 | Current reinit bit |
| tx_sof | input | 1 | Transmit path starts a frame |
| tx_eof | input | 1 | Transmit path ends a frame |
| rx_sof | input | 1 | Receive path starts a frame |
| rx_eof | input | 1 | Receive path ends a frame |
| tx_gate | output | 1 | Transmit beats may move |
| tx_abort | output | 1 | One-cycle strobe: truncate the transmit frame |
| tx_active | output | 1 | Transmit may start a new frame |
| tx_idle | output | 1 | Transmit stopped with no open frame |
| rx_gate | output | 1 | Receive beats may move |
| rx_abort | output | 1 | One-cycle strobe: truncate the receive frame |
| rx_active | output | 1 | Receive may start a new frame |
| rx_idle | output | 1 | Receive stopped with no open frame |

## Verification
The hardest cases to reach are the ones where a stray start-of-frame strobe is silently rejected. From the outputs, a rejected strobe and a single-beat frame look the same as an idle, open direction. The stimulus therefore follows each such strobe with a write that sets the stop bit. If a frame had wrongly opened, the direction would show a draining gate. If not, it shows idle. The same probe is used for a start-of-frame strobe that arrives in the same cycle as the write enabling the direction, and for one that arrives while the reinit bit is held.

// File: rtl/mac_gate_pkg.sv
// Shared types for the MAC run gate.
// Assumes exactly two directions, transmit at index 0 and receive at index 1.
package mac_gate_pkg;

    localparam int NUM_DIR = 2;
    localparam int DIR_TX  = 0;
    localparam int DIR_RX  = 1;

    // Control bits of one direction as the host sees them.
    typedef struct packed {
        logic run;
        logic stop;
    } dir_cfg_t;

    // Status presented to one path.
    typedef struct packed {
        logic gate;
        logic abort;
        logic active;
        logic idle;
    } dir_stat_t;

    // Derived condition of one direction.
    typedef enum logic [2:0] {
        DS_OFF   = 3'd0,   // no frame, not accepting
        DS_READY = 3'd1,   // no frame, accepting
        DS_FRAME = 3'd2,   // frame open, running
        DS_DRAIN = 3'd3,   // frame open, stop pending at frame end
        DS_CUT   = 3'd4    // frame open, run bit gone: abort
    } dir_state_e;

endpackage

// File: rtl/gate_ctl_regs.sv
// Control bits of the run gate: a run and a stop bit per direction plus a
// sticky reinit bit. Assumes one host write strobe that loads all bits at
// once. A write carrying reinit forces every stop bit high and every run bit
// low. Reinit only clears through a write that carries reinit=0.
module gate_ctl_regs
    import mac_gate_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr,
    input  dir_cfg_t [NUM_DIR-1:0]  wr_cfg,
    input  logic                    wr_reinit,
    output dir_cfg_t [NUM_DIR-1:0]  cfg,
    output logic                    reinit
);

    dir_cfg_t [NUM_DIR-1:0] cfg_q;
    dir_cfg_t [NUM_DIR-1:0] cfg_d;
    logic                   reinit_q;

    // Apply the reinit override to the incoming write data.
    always_comb begin
        for (int d = 0; d < NUM_DIR; d++) begin
            cfg_d[d].run  = wr_cfg[d].run & ~wr_reinit;
            cfg_d[d].stop = wr_cfg[d].stop | wr_reinit;
        end
    end

    // Hold the control bits; load them on a host write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q    <= '0;
            reinit_q <= 1'b0;
        end else if (wr) begin
            cfg_q    <= cfg_d;
            reinit_q <= wr_reinit;
        end
    end

    assign cfg    = cfg_q;
    assign reinit = reinit_q;

endmodule

// File: rtl/frame_tracker.sv
// Tracks whether one path has a frame open. A frame opens on a start strobe
// seen while starts are allowed, and closes on an end strobe or on a kill.
// Assumes the path never raises an end strobe for a frame it did not start.
// A stray end strobe with no open frame is harmless.
module frame_tracker (
    input  logic clk,
    input  logic rst_n,
    input  logic sof,
    input  logic eof,
    input  logic start_ok,
    input  logic kill,
    output logic in_frame
);

    logic open_q;
    logic open_d;

    // Next frame-open state from the boundary strobes.
    always_comb begin
        if (kill) begin
            open_d = 1'b0;
        end else if (open_q) begin
            open_d = ~eof;
        end else begin
            open_d = sof & start_ok & ~eof;
        end
    end

    // Register the frame-open flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            open_q <= 1'b0;
        end else begin
            open_q <= open_d;
        end
    end

    assign in_frame = open_q;

endmodule

// File: rtl/dir_gate.sv
// Gating for one direction. It combines the direction's run and stop bits
// with the frame-open flag into a condition, and decodes that condition into
// the gate, abort, active and idle outputs. Assumes the control bits come
// from registers, so every output depends only on state.
module dir_gate
    import mac_gate_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  dir_cfg_t  cfg,
    input  logic      sof,
    input  logic      eof,
    output dir_stat_t stat
);

    logic       in_frame;
    logic       start_ok;
    dir_state_e state;

    assign start_ok = cfg.run & ~cfg.stop;

    frame_tracker u_track (
        .clk      (clk),
        .rst_n    (rst_n),
        .sof      (sof),
        .eof      (eof),
        .start_ok (start_ok),
        .kill     (~cfg.run),
        .in_frame (in_frame)
    );

    // Classify the direction from its control bits and frame flag.
    always_comb begin
        if (!in_frame) begin
            state = start_ok ? DS_READY : DS_OFF;
        end else if (!cfg.run) begin
            state = DS_CUT;
        end else if (cfg.stop) begin
            state = DS_DRAIN;
        end else begin
            state = DS_FRAME;
        end
    end

    // Decode the condition into the status presented to the path.
    always_comb begin
        stat = '0;
        unique case (state)
            DS_OFF:   stat.idle   = 1'b1;
            DS_READY: begin
                stat.gate   = 1'b1;
                stat.active = 1'b1;
            end
            DS_FRAME: begin
                stat.gate   = 1'b1;
                stat.active = 1'b1;
            end
            DS_DRAIN: stat.gate   = 1'b1;
            DS_CUT:   stat.abort  = 1'b1;
            default:  stat      = '0;
        endcase
    end

endmodule

// File: rtl/mac_run_gate.sv
// Top of the MAC run gate. It holds the control bits and gates the transmit
// and receive paths, one dir_gate per direction. Assumes a synchronous,
// active-low reset and boundary strobes that are synchronous to clk.
module mac_run_gate
    import mac_gate_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cfg_wr,
    input  logic cfg_tx_run,
    input  logic cfg_tx_stop,
    input  logic cfg_rx_run,
    input  logic cfg_rx_stop,
    input  logic cfg_reinit,
    output logic stat_tx_run,
    output logic stat_tx_stop,
    output logic stat_rx_run,
    output logic stat_rx_stop,
    output logic stat_reinit,
    input  logic tx_sof,
    input  logic tx_eof,
    input  logic rx_sof,
    input  logic rx_eof,
    output logic tx_gate,
    output logic tx_abort,
    output logic tx_active,
    output logic tx_idle,
    output logic rx_gate,
    output logic rx_abort,
    output logic rx_active,
    output logic rx_idle
);

    dir_cfg_t  [NUM_DIR-1:0] wr_cfg;
    dir_cfg_t  [NUM_DIR-1:0] cfg;
    dir_stat_t [NUM_DIR-1:0] stat;
    logic      [NUM_DIR-1:0] sof;
    logic      [NUM_DIR-1:0] eof;

    // Gather the per-direction port signals into arrays.
    always_comb begin
        wr_cfg[DIR_TX] = '{run: cfg_tx_run, stop: cfg_tx_stop};
        wr_cfg[DIR_RX] = '{run: cfg_rx_run, stop: cfg_rx_stop};
        sof            = '0;
        eof            = '0;
        sof[DIR_TX]    = tx_sof;
        sof[DIR_RX]    = rx_sof;
        eof[DIR_TX]    = tx_eof;
        eof[DIR_RX]    = rx_eof;
    end

    gate_ctl_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr        (cfg_wr),
        .wr_cfg    (wr_cfg),
        .wr_reinit (cfg_reinit),
        .cfg       (cfg),
        .reinit    (stat_reinit)
    );

    for (genvar d = 0; d < NUM_DIR; d++) begin : g_dir
        dir_gate u_gate (
            .clk   (clk),
            .rst_n (rst_n),
            .cfg   (cfg[d]),
            .sof   (sof[d]),
            .eof   (eof[d]),
            .stat  (stat[d])
        );
    end

    assign stat_tx_run  = cfg[DIR_TX].run;
    assign stat_tx_stop = cfg[DIR_TX].stop;
    assign stat_rx_run  = cfg[DIR_RX].run;
    assign stat_rx_stop = cfg[DIR_RX].stop;

    assign tx_gate   = stat[DIR_TX].gate;
    assign tx_abort  = stat[DIR_TX].abort;
    assign tx_active = stat[DIR_TX].active;
    assign tx_idle   = stat[DIR_TX].idle;
    assign rx_gate   = stat[DIR_RX].gate;
    assign rx_abort  = stat[DIR_RX].abort;
    assign rx_active = stat[DIR_RX].active;
    assign rx_idle   = stat[DIR_RX].idle;

endmodule

// File: rtl/mac_run_gate_chk.sv
// Assertion checker for mac_run_gate, attached by bind. It sees only the
// top-level ports.
module mac_run_gate_chk (
    input logic clk,
    input logic rst_n,
    input logic cfg_wr,
    input logic cfg_tx_run,
    input logic cfg_reinit,
    input logic stat_tx_run,
    input logic stat_tx_stop,
    input logic stat_rx_run,
    input logic stat_rx_stop,
    input logic stat_reinit,
    input logic tx_eof,
    input logic tx_gate,
    input logic tx_abort,
    input logic tx_active,
    input logic tx_idle,
    input logic rx_gate,
    input logic rx_abort,
    input logic rx_active,
    input logic rx_idle
);

    AST_TX_ABORT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        tx_abort |=> !tx_abort); // R4
    AST_RX_ABORT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        rx_abort |=> !rx_abort); // R4
    AST_TX_ABORT_CLOSED: assert property (@(posedge clk) disable iff (!rst_n)
        tx_abort |-> (!tx_gate && !stat_tx_run)); // R4
    AST_RX_ABORT_CLOSED: assert property (@(posedge clk) disable iff (!rst_n)
        rx_abort |-> (!rx_gate && !stat_rx_run)); // R4
    AST_TX_DRAIN_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_gate && !tx_active && !tx_eof && !(cfg_wr && !cfg_tx_run) && !(cfg_wr && cfg_reinit))
        |=> (tx_gate && !tx_abort)); // R5
    AST_REINIT_FORCES: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && cfg_reinit) |=> (stat_reinit && stat_tx_stop && stat_rx_stop
                                    && !stat_tx_run && !stat_rx_run)); // R7
    AST_REINIT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_reinit && !(cfg_wr && !cfg_reinit)) |=> stat_reinit); // R9
    AST_TX_IDLE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        tx_idle |-> (!tx_active && !tx_gate && !tx_abort)); // R10
    AST_RX_IDLE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        rx_idle |-> (!rx_active && !rx_gate && !rx_abort)); // R10

endmodule

bind mac_run_gate mac_run_gate_chk i_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_wr       (cfg_wr),
    .cfg_tx_run   (cfg_tx_run),
    .cfg_reinit   (cfg_reinit),
    .stat_tx_run  (stat_tx_run),
    .stat_tx_stop (stat_tx_stop),
    .stat_rx_run  (stat_rx_run),
    .stat_rx_stop (stat_rx_stop),
    .stat_reinit  (stat_reinit),
    .tx_eof       (tx_eof),
    .tx_gate      (tx_gate),
    .tx_abort     (tx_abort),
    .tx_active    (tx_active),
    .tx_idle      (tx_idle),
    .rx_gate      (rx_gate),
    .rx_abort     (rx_abort),
    .rx_active    (rx_active),
    .rx_idle      (rx_idle)
);

// File: tb/test_mac_run_gate.sv
// Scoreboard bench for mac_run_gate. The driver applies inputs at the falling
// edge and pushes the expected port values for after the next rising edge.
// The monitor pops and compares those values a quarter period after each
// rising edge.
// Expected vector layout: {reinit, rx_stop, rx_run, tx_stop, tx_run,
//                          tx{gate,abort,active,idle}, rx{gate,abort,active,idle}}
module test_mac_run_gate;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_wr = 1'b0, cfg_tx_run = 1'b0, cfg_tx_stop = 1'b0;
    logic cfg_rx_run = 1'b0, cfg_rx_stop = 1'b0, cfg_reinit = 1'b0;
    logic tx_sof = 1'b0, tx_eof = 1'b0, rx_sof = 1'b0, rx_eof = 1'b0;
    logic stat_tx_run, stat_tx_stop, stat_rx_run, stat_rx_stop, stat_reinit;
    logic tx_gate, tx_abort, tx_active, tx_idle;
    logic rx_gate, rx_abort, rx_active, rx_idle;

    localparam logic [3:0] OFF = 4'b0001;
    localparam logic [3:0] RUN = 4'b1010;
    localparam logic [3:0] DRN = 4'b1000;
    localparam logic [3:0] CUT = 4'b0100;

    typedef struct {
        logic [12:0] v;
        string       tag;
    } exp_t;

    exp_t exp_q[$];
    int   n_cmp = 0;
    int   n_bad = 0;
    bit   done = 1'b0;

    always #10 clk = ~clk;

    mac_run_gate i_mac_run_gate (.*);

    // Monitor: compare each expected item after the edge it describes.
    always @(posedge clk) begin
        #5;
        if (exp_q.size() > 0) begin
            exp_t e;
            logic [12:0] act;
            e   = exp_q.pop_front();
            act = {stat_reinit, stat_rx_stop, stat_rx_run, stat_tx_stop, stat_tx_run,
                   tx_gate, tx_abort, tx_active, tx_idle,
                   rx_gate, rx_abort, rx_active, rx_idle};
            n_cmp++;
            if (act !== e.v) begin
                n_bad++;
                $display("FAIL %s: actual %b expected %b", e.tag, act, e.v);
            end
        end
    end

    // Driver: queue the expectation, run one cycle, then drop the strobes.
    task automatic step(input logic [4:0] regs, input logic [3:0] tx,
                        input logic [3:0] rx, input string tag);
        exp_t e;
        e.v   = {regs, tx, rx};
        e.tag = tag;
        exp_q.push_back(e);
        @(negedge clk);
        cfg_wr = 1'b0; cfg_reinit = 1'b0;
        tx_sof = 1'b0; tx_eof = 1'b0; rx_sof = 1'b0; rx_eof = 1'b0;
    endtask

    task automatic wr(input logic txr, input logic txs, input logic rxr,
                      input logic rxs, input logic ri);
        cfg_wr = 1'b1; cfg_tx_run = txr; cfg_tx_stop = txs;
        cfg_rx_run = rxr; cfg_rx_stop = rxs; cfg_reinit = ri;
    endtask

    initial begin
        @(negedge clk);
        step(5'b00000, OFF, OFF, "R1 reset");
        tx_sof = 1'b1; wr(1, 0, 1, 0, 0);
        step(5'b00000, OFF, OFF, "R1 reset holds against write");
        rst_n = 1'b1;
        step(5'b00000, OFF, OFF, "R1 after release");
        wr(1, 0, 0, 0, 0);
        step(5'b00001, RUN, OFF, "R2 tx run loaded");
        tx_sof = 1'b1;
        step(5'b00001, RUN, OFF, "R10 tx frame open, not idle");
        step(5'b00001, RUN, OFF, "R2 bits hold");
        wr(0, 0, 0, 0, 0);
        step(5'b00000, CUT, OFF, "R4 tx cut mid-frame");
        step(5'b00000, OFF, OFF, "R4 abort single cycle");
        wr(1, 0, 0, 0, 0); tx_sof = 1'b1;
        step(5'b00001, RUN, OFF, "R3 sof with enabling write");
        wr(1, 1, 0, 0, 0);
        step(5'b00011, OFF, OFF, "R3 sof before enable ignored");
        wr(1, 0, 0, 0, 0);
        step(5'b00001, RUN, OFF, "R3 tx active");
        tx_sof = 1'b1;
        step(5'b00001, RUN, OFF, "R3 tx frame open");
        wr(1, 1, 0, 0, 0);
        step(5'b00011, DRN, OFF, "R5 tx draining");
        tx_sof = 1'b1;
        step(5'b00011, DRN, OFF, "R5 drain holds");
        tx_eof = 1'b1;
        step(5'b00011, OFF, OFF, "R5 stop at frame end");
        tx_eof = 1'b1; tx_sof = 1'b1;
        step(5'b00011, OFF, OFF, "R11 eof with no frame");
        wr(1, 0, 1, 0, 0);
        step(5'b00101, RUN, RUN, "R2 both run");
        rx_sof = 1'b1; rx_eof = 1'b1;
        step(5'b00101, RUN, RUN, "R11 single-beat rx frame");
        wr(1, 0, 1, 1, 0);
        step(5'b01101, RUN, OFF, "R11 no rx frame left open");
        wr(1, 0, 1, 0, 0);
        step(5'b00101, RUN, RUN, "R2 rx reopened");
        rx_sof = 1'b1; tx_sof = 1'b1;
        step(5'b00101, RUN, RUN, "R6 both frames open");
        wr(1, 0, 0, 0, 0);
        step(5'b00001, RUN, CUT, "R6 rx cut, tx untouched");
        step(5'b00001, RUN, OFF, "R4 rx abort single cycle");
        wr(1, 0, 1, 0, 0);
        step(5'b00101, RUN, RUN, "R6 rx reopened, tx frame still open");
        rx_sof = 1'b1;
        step(5'b00101, RUN, RUN, "R6 rx frame open");
        wr(1, 0, 1, 0, 1);
        step(5'b11010, CUT, CUT, "R7 reinit aborts both");
        step(5'b11010, OFF, OFF, "R9 reinit holds");
        wr(1, 0, 1, 0, 1); tx_sof = 1'b1;
        step(5'b11010, OFF, OFF, "R8 run forced low under reinit");
        tx_sof = 1'b1; rx_sof = 1'b1;
        step(5'b11010, OFF, OFF, "R9 reinit sticky");
        wr(1, 1, 0, 0, 0);
        step(5'b00011, OFF, OFF, "R9 reinit cleared, bits loaded");
        wr(1, 0, 0, 0, 0);
        step(5'b00001, RUN, OFF, "R10 tx active not idle");
        wr(1, 1, 0, 0, 0);
        step(5'b00011, OFF, OFF, "R10 stop with no frame is idle");
        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    // Watchdog: a hung run counts as one failed comparison.
    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule